// File: doc/BRIEF.md
# In-Order Retire Slot Tracker

This block follows every instruction from dispatch to retirement in a circular buffer with a fixed number of slots. At dispatch an instruction asks for some number of micro-op slots. If that many are free, it takes a run of consecutive slots starting at the tail. It gets back a token, which is the index of its first slot. When the instruction finishes executing, write-back returns that token on the notify port and the entry is marked executed.

Each cycle the block walks the buffer from the head. It retires executed instructions strictly in program order and stops at the first entry that has not executed or when it reaches the per-cycle retire limit. Each retirement puts the instruction's index on a retire lane and returns its slots to the free pool at the next clock edge. Status outputs show whether the current request fits and whether the buffer is full or empty. The buffer must have at least one slot.

Top module: `rob_slot_tracker`

## Requirements
- R1: After reset the buffer is empty, `empty_o`=1, `full_o`=0, and no retire lane is valid.
- R2: `rsv_token_o` is the slot index where the next reservation starts. An accepted reservation moves that index forward by the number of slots it reserved, wrapping modulo SLOTS.
- R3: Retirement starts at the head and keeps program order. Only entries marked executed retire. The walk stops at the first non-executed entry, so an executed entry behind it waits.
- R4: At most RET_MAX instructions retire per cycle. RET_MAX=0 means no limit, so up to SLOTS lanes are used.
- R5: A request larger than SLOTS counts as exactly SLOTS slots. A request of zero counts as one slot.
- R6: `avail_o` is 1 exactly when the free-slot count is at least the adjusted request size. A request made while `avail_o`=0 is ignored: the token and the free count stay unchanged.
- R7: `full_o` is 1 when no slot is free. `empty_o` is 1 when all SLOTS slots are free.
- R8: At the edge that ends a retire cycle, the slots of the retired instructions become free again.
- R9: Lane k of `retire_valid_o` / `retire_idx_o` (index at bits k*IDX_W and up) carries the k-th retirement of the cycle. It holds the index that was given at dispatch. Valid lanes fill from lane 0 upward with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsv_valid_i | input | 1 | Reservation request |
| rsv_uops_i | input | UOP_W | Micro-op count requested |
| rsv_idx_i | input | IDX_W | Instruction index to store |
| rsv_token_o | output | PTR_W | Token (first slot) for the current request |
| avail_o | output | 1 | Current request fits in free slots |
| full_o | output | 1 | No free slot |
| empty_o | output | 1 | All slots free |
| exec_valid_i | input | 1 | Write-back notify |
| exec_token_i | input | PTR_W | Token of the executed instruction |
| retire_valid_o | output | LANES | Retire lane valid bits |
| retire_idx_o | output | LANES*IDX_W | Retired instruction indices, lane 0 lowest |

## Verification
Token, availability, full and empty are combinational from the current state. An accepted reservation shows in them right after the next rising edge. A notify taken at an edge makes the retire lanes valid for the whole following cycle, and the freed slots appear one edge later. The bench drives inputs just after each falling edge and samples one time unit later. So every check reads the state left by exactly the rising edges it has counted.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // adjusted slot count for a request: 0 -> 1, capped at slots
  function automatic int unsigned cap_req(int unsigned n, int unsigned slots);
    if (n == 0) return 1;
    if (n > slots) return slots;
    return n;
  endfunction

  function automatic int unsigned wrap_add(int unsigned p, int unsigned n, int unsigned slots);
    int unsigned s;
    s = p + n;
    return (s >= slots) ? s - slots : s;
  endfunction
endpackage

// File: rtl/rob_free_ctr.sv
module rob_free_ctr #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] take_i,
  input  logic [CNT_W-1:0] give_i,
  output logic [CNT_W-1:0] free_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [CNT_W-1:0] free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= CNT_W'(SLOTS);
    else         free_q <= free_q - take_i + give_i;
  end

  assign free_o  = free_q;
  assign full_o  = (free_q == '0);
  assign empty_o = (free_q == CNT_W'(SLOTS));

  p_take_fits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i <= free_q);
  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, give_i} <= (CNT_W+1)'(SLOTS) - {1'b0, free_q});
endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel import rob_pkg::*; #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned LANES = 2,
  parameter int unsigned PTR_W = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic [PTR_W-1:0]             head_i,
  input  logic [CNT_W-1:0]             occ_i,
  input  logic [SLOTS-1:0]             vld_i,
  input  logic [SLOTS-1:0]             exe_i,
  input  logic [SLOTS-1:0][CNT_W-1:0]  ns_i,
  input  logic [SLOTS-1:0][IDX_W-1:0]  idx_i,
  output logic [LANES-1:0]             ret_vld_o,
  output logic [LANES*IDX_W-1:0]       ret_idx_o,
  output logic [SLOTS-1:0]             ret_clr_o,
  output logic [PTR_W-1:0]             head_nxt_o,
  output logic [CNT_W-1:0]             freed_o
);
  always_comb begin : walk
    logic [PTR_W-1:0] p;
    logic [CNT_W:0]   acc;
    logic             go;
    p = head_i;
    acc = '0;
    go = 1'b1;
    ret_vld_o = '0;
    ret_idx_o = '0;
    ret_clr_o = '0;
    for (int k = 0; k < LANES; k++) begin
      // acc < occ guards against re-visiting a slot after a full wrap
      if (go && (acc < {1'b0, occ_i}) && vld_i[p] && exe_i[p]) begin
        ret_vld_o[k] = 1'b1;
        ret_idx_o[k*IDX_W +: IDX_W] = idx_i[p];
        ret_clr_o[p] = 1'b1;
        acc = acc + {1'b0, ns_i[p]};
        p = PTR_W'(wrap_add(32'(p), 32'(ns_i[p]), SLOTS));
      end else begin
        go = 1'b0;
      end
    end
    head_nxt_o = p;
    freed_o    = CNT_W'(acc);
  end
endmodule

// File: rtl/rob_slot_tracker.sv
module rob_slot_tracker import rob_pkg::*; #(
  parameter int unsigned SLOTS   = 8,
  parameter int unsigned RET_MAX = 2,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned UOP_W   = 5,
  localparam int unsigned PTR_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1),
  localparam int unsigned LANES  = (RET_MAX == 0 || RET_MAX > SLOTS) ? SLOTS : RET_MAX
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rsv_valid_i,
  input  logic [UOP_W-1:0]       rsv_uops_i,
  input  logic [IDX_W-1:0]       rsv_idx_i,
  output logic [PTR_W-1:0]       rsv_token_o,
  output logic                   avail_o,
  output logic                   full_o,
  output logic                   empty_o,
  input  logic                   exec_valid_i,
  input  logic [PTR_W-1:0]       exec_token_i,
  output logic [LANES-1:0]       retire_valid_o,
  output logic [LANES*IDX_W-1:0] retire_idx_o
);
  logic [SLOTS-1:0]            vld_q, exe_q, vld_d, exe_d, clr;
  logic [SLOTS-1:0][IDX_W-1:0] idx_q;
  logic [SLOTS-1:0][CNT_W-1:0] ns_q;
  logic [PTR_W-1:0]            head_q, tail_q, head_nxt;
  logic [CNT_W-1:0]            free, req_n, freed, take;
  logic                        fire;

  assign req_n       = CNT_W'(cap_req(32'(rsv_uops_i), SLOTS));
  assign avail_o     = (free >= req_n);
  assign fire        = rsv_valid_i & avail_o;
  assign take        = fire ? req_n : '0;
  assign rsv_token_o = tail_q;

  rob_free_ctr #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_free (
    .clk_i, .rst_ni, .take_i(take), .give_i(freed),
    .free_o(free), .full_o(full_o), .empty_o(empty_o)
  );

  rob_retire_sel #(.SLOTS(SLOTS), .IDX_W(IDX_W), .LANES(LANES),
                   .PTR_W(PTR_W), .CNT_W(CNT_W)) u_sel (
    .head_i(head_q), .occ_i(CNT_W'(SLOTS) - free), .vld_i(vld_q), .exe_i(exe_q),
    .ns_i(ns_q), .idx_i(idx_q), .ret_vld_o(retire_valid_o),
    .ret_idx_o(retire_idx_o), .ret_clr_o(clr), .head_nxt_o(head_nxt),
    .freed_o(freed)
  );

  always_comb begin
    vld_d = vld_q & ~clr;
    exe_d = exe_q & ~clr;
    if (exec_valid_i) exe_d[exec_token_i] = vld_q[exec_token_i];
    if (fire) begin
      vld_d[tail_q] = 1'b1;
      exe_d[tail_q] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      exe_q  <= '0;
      idx_q  <= '0;
      ns_q   <= '0;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      vld_q  <= vld_d;
      exe_q  <= exe_d;
      head_q <= head_nxt;
      if (fire) begin
        idx_q[tail_q] <= rsv_idx_i;
        ns_q[tail_q]  <= req_n;
        tail_q        <= PTR_W'(wrap_add(32'(tail_q), 32'(req_n), SLOTS));
      end
    end
  end

  p_exec_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid_i |-> vld_q[exec_token_i]);
  p_lanes_packed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(LANES'(retire_valid_o + 1'b1)));
  p_free_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire && retire_valid_o == '0) |=> $stable(free));
  p_full_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  p_no_retire_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> retire_valid_o == '0);
endmodule

// File: tb/tb_rob_slot_tracker.sv
module tb_rob_slot_tracker;
  localparam int unsigned IDX_W = 8;
  logic clk_i = 0, rst_ni = 0;
  logic rsv_valid_i = 0;
  logic [4:0] rsv_uops_i = '0;
  logic [IDX_W-1:0] rsv_idx_i = '0;
  logic [2:0] rsv_token_o, exec_token_i = '0;
  logic avail_o, full_o, empty_o, exec_valid_i = 0;
  logic [1:0] retire_valid_o;
  logic [2*IDX_W-1:0] retire_idx_o;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  rob_slot_tracker dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic rsv(input logic v, input int u, input int i);
    rsv_valid_i = v; rsv_uops_i = 5'(u); rsv_idx_i = IDX_W'(i);
  endtask

  task automatic exe(input logic v, input int t);
    exec_valid_i = v; exec_token_i = 3'(t);
  endtask

  function automatic int lane(input int k);
    return int'(retire_idx_o[k*IDX_W +: IDX_W]);
  endfunction

  task automatic t_reset();
    #1;
    chk("R1 empty", empty_o, 1);
    chk("R1 full", full_o, 0);
    chk("R1 retire", retire_valid_o, 0);
  endtask

  task automatic t_basic();
    @(negedge clk_i); rsv(1, 3, 10); #1 chk("R2 token", rsv_token_o, 0);
    chk("R6 avail", avail_o, 1);
    @(negedge clk_i); rsv(1, 2, 11); #1 chk("R2 token", rsv_token_o, 3);
    @(negedge clk_i); rsv(0, 1, 0); exe(1, 3); #1 chk("R7 empty", empty_o, 0);
    @(negedge clk_i); exe(0, 0); #1 chk("R3 head blocks", retire_valid_o, 0);
    @(negedge clk_i); exe(1, 0);
    @(negedge clk_i); exe(0, 0); #1 chk("R3 retire both", retire_valid_o, 3);
    chk("R9 lane0 idx", lane(0), 10);
    chk("R9 lane1 idx", lane(1), 11);
    @(negedge clk_i); #1 chk("R8 freed", empty_o, 1);
    chk("R3 no retire", retire_valid_o, 0);
  endtask

  task automatic t_limit();
    @(negedge clk_i); rsv(1, 1, 20); #1 chk("R2 token", rsv_token_o, 5);
    @(negedge clk_i); rsv(1, 1, 21); #1 chk("R2 token", rsv_token_o, 6);
    @(negedge clk_i); rsv(1, 1, 22); #1 chk("R2 token", rsv_token_o, 7);
    @(negedge clk_i); rsv(0, 1, 0); exe(1, 7);
    @(negedge clk_i); exe(1, 6);
    @(negedge clk_i); exe(0, 0); #1 chk("R3 waits on head", retire_valid_o, 0);
    chk("R2 wrap", rsv_token_o, 0);
    exe(1, 5);
    @(negedge clk_i); exe(0, 0); #1 chk("R4 limit", retire_valid_o, 3);
    chk("R4 lane0", lane(0), 20);
    chk("R4 lane1", lane(1), 21);
    @(negedge clk_i); #1 chk("R4 rest", retire_valid_o, 1);
    chk("R4 rest idx", lane(0), 22);
    @(negedge clk_i); #1 chk("R8 empty", empty_o, 1);
  endtask

  task automatic t_cap();
    @(negedge clk_i); rsv(1, 20, 30); #1 chk("R5 cap avail", avail_o, 1);
    chk("R5 token", rsv_token_o, 0);
    @(negedge clk_i); rsv(0, 1, 0); #1 chk("R7 full", full_o, 1);
    chk("R6 no room", avail_o, 0);
    chk("R5 tail wraps", rsv_token_o, 0);
    exe(1, 0);
    @(negedge clk_i); exe(0, 0); #1 chk("R5 single retire", retire_valid_o, 1);
    chk("R5 idx", lane(0), 30);
    @(negedge clk_i); #1 chk("R8 empty", empty_o, 1);
    chk("R8 avail", avail_o, 1);
  endtask

  task automatic t_zero();
    @(negedge clk_i); rsv(1, 0, 40); #1 chk("R2 token", rsv_token_o, 0);
    @(negedge clk_i); rsv(1, 1, 41); #1 chk("R5 zero is one", rsv_token_o, 1);
    @(negedge clk_i); rsv(0, 1, 0); exe(1, 0);
    @(negedge clk_i); exe(1, 1); #1 chk("R3 first", retire_valid_o, 1);
    chk("R9 idx", lane(0), 40);
    @(negedge clk_i); exe(0, 0); #1 chk("R3 second", retire_valid_o, 1);
    chk("R9 idx", lane(0), 41);
    @(negedge clk_i); #1 chk("R8 empty", empty_o, 1);
  endtask

  task automatic t_nospace();
    @(negedge clk_i); rsv(1, 6, 50); #1 chk("R2 token", rsv_token_o, 2);
    @(negedge clk_i); rsv(1, 3, 51); #1 chk("R6 too big", avail_o, 0);
    chk("R2 wrap", rsv_token_o, 0);
    @(negedge clk_i); rsv(0, 2, 0); #1 chk("R6 ignored token", rsv_token_o, 0);
    chk("R6 ignored avail", avail_o, 1);
    chk("R7 not full", full_o, 0);
    exe(1, 2);
    @(negedge clk_i); exe(0, 0); #1 chk("R3 retire", retire_valid_o, 1);
    chk("R9 idx", lane(0), 50);
    @(negedge clk_i); #1 chk("R8 empty", empty_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    t_basic();
    t_limit();
    t_cap();
    t_zero();
    t_nospace();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      nchk++; nbad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule